// File: doc/BRIEF.md
# I/O Instruction Decoder with Device Strobes

This block turns the processor's machine-cycle status into per-device select signals for a small I/O bus. It watches the 2-bit CPU state code and the 4-bit N field that the processor presents while it executes an I/O instruction. When an I/O execute cycle begins, it raises one sync line for the N value. That line stays high for the whole machine cycle. The block also reports the transfer direction, taken from the top bit of N.

For write cycles (memory to I/O bus), one device strobe is pulsed late in the cycle, at the second timing pulse, when the memory data has settled. A module enable input lets an external device-address decoder qualify the whole block. With it the block can serve as the second level of a two-level device selection scheme. Tied high, the block is always selected.

All outputs are registered on the system clock. The two timing pulses are single-clock qualifiers. The first one opens a machine cycle and the second one marks valid memory data.

Top module: `io_decoder`

## Requirements
- R1: The state code encodes fetch as 00, execute as 01, DMA as 10 and interrupt as 11. An I/O cycle is recognised only when the state code is 01 at the clock edge where `tpa` is high. Any other state at that edge yields no sync, no strobe and a direction of 0.
- R2: In a recognised I/O cycle, `io_sync[n]` goes high in the clock after the `tpa` edge. It is the only sync bit high, and it stays high until the next edge where `tpa` is high.
- R3: N values 0 and 8 (low three bits zero) never produce a sync or a strobe.
- R4: `io_dir` equals bit 3 of the latched N during a recognised I/O cycle: 1 means read (I/O bus into memory, N 9 to F) and 0 means write (memory to I/O bus, N 1 to 7). It is 0 when no I/O cycle is active.
- R5: For a write cycle with N 1 to 7, `io_strobe[n]` is high for exactly one clock, in the clock after the edge where `tpb` is high. No other strobe bit is high at that time.
- R6: Read cycles (N 9 to F) never produce a strobe.
- R7: If `mod_en` is low at the `tpa` edge, the cycle produces no sync, no strobe and a direction of 0.
- R8: In the clock after any edge where `rst` (CPU clear) is high, all sync and strobe outputs and the direction output are 0.
- R9: A `tpa` edge that starts a non-I/O cycle clears the sync and direction outputs of the previous cycle in the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high CPU clear |
| cpu_state | input | 2 | CPU state code (01 = execute) |
| n_field | input | 4 | Instruction N field |
| tpa | input | 1 | First timing pulse, opens a machine cycle |
| tpb | input | 1 | Second timing pulse, memory data valid |
| mod_en | input | 1 | Module enable from the first-level decoder |
| io_sync | output | 16 | One sync line per N value, held for the machine cycle |
| io_strobe | output | 8 | Write strobes, indexed by the low three bits of N |
| io_dir | output | 1 | Transfer direction, 1 = read into memory |

## Verification
A wrong latched N or a lost cycle-valid bit appears on `io_sync` and `io_dir` one clock after the `tpa` edge. The error persists until the next `tpa`, so any sample within the machine cycle exposes it. A wrong write flag or strobe index appears only in the single clock after `tpb`, so the scoreboard compares every clock rather than once per machine cycle. Stale state that survives a non-I/O cycle, an enable-low cycle or a clear shows up as a high sync bit one clock after the clearing edge.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

    localparam int N_W    = 4;
    localparam int SYNC_N = 1 << N_W;
    localparam int STB_N  = 1 << (N_W - 1);
    localparam int IDX_W  = N_W - 1;

    typedef enum logic [1:0] {
        ST_FETCH = 2'b00,
        ST_EXEC  = 2'b01,
        ST_DMA   = 2'b10,
        ST_INTR  = 2'b11
    } cpu_state_e;

    typedef struct packed {
        logic             valid;
        logic             rd;
        logic [N_W-1:0]   sel;
    } io_cmd_t;

    function automatic io_cmd_t decode_cmd(input logic [1:0] st,
                                           input logic [N_W-1:0] n,
                                           input logic en);
        io_cmd_t c;
        c.valid = en && (cpu_state_e'(st) == ST_EXEC) && (n[IDX_W-1:0] != '0);
        c.rd    = c.valid && n[N_W-1];
        c.sel   = n;
        return c;
    endfunction

endpackage

// File: rtl/io_cmd_decode.sv
module io_cmd_decode
    import io_dec_pkg::*;
(
    input  logic [1:0]     state_i,
    input  logic [N_W-1:0] n_i,
    input  logic           en_i,
    output io_cmd_t        cmd_o
);

    always_comb begin
        cmd_o = decode_cmd(state_i, n_i, en_i);
    end

    always_comb begin
        if (cmd_o.valid) begin
            assert (cmd_o.sel[IDX_W-1:0] != '0); // R3
        end
    end

endmodule

// File: rtl/io_sync_frame.sv
module io_sync_frame
    import io_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tpa_i,
    input  io_cmd_t           cmd_i,
    output logic [SYNC_N-1:0] sync_o,
    output logic              rd_o,
    output logic              wr_act_o,
    output logic [IDX_W-1:0]  idx_o
);

    io_cmd_t cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (tpa_i) begin
            cur_q <= cmd_i;
        end
    end

    genvar g;
    generate
        for (g = 0; g < SYNC_N; g++) begin : g_sync
            assign sync_o[g] = cur_q.valid && (cur_q.sel == N_W'(g));
        end
    endgenerate

    assign rd_o     = cur_q.rd;
    assign wr_act_o = cur_q.valid && !cur_q.rd;
    assign idx_o    = cur_q.sel[IDX_W-1:0];

    AST_SYNC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sync_o)); // R2
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tpa_i |=> $stable(sync_o)); // R2
    AST_NO_NULL_SYNC: assert property (@(posedge clk) disable iff (rst)
        !sync_o[0] && !sync_o[STB_N]); // R3
    AST_DIR_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
        rd_o |-> (|sync_o[SYNC_N-1:STB_N])); // R4

endmodule

// File: rtl/io_strobe_gen.sv
module io_strobe_gen
    import io_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tpb_i,
    input  logic             wr_act_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [STB_N-1:0] strobe_o
);

    logic [STB_N-1:0] stb_d;

    genvar g;
    generate
        for (g = 0; g < STB_N; g++) begin : g_stb
            assign stb_d[g] = tpb_i && wr_act_i && (idx_i == IDX_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_o <= '0;
        end else begin
            strobe_o <= stb_d;
        end
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o)); // R5
    AST_STB_AFTER_TPB: assert property (@(posedge clk) disable iff (rst)
        !tpb_i |=> (strobe_o == '0)); // R5
    AST_STB_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (|strobe_o) |-> $past(wr_act_i)); // R6
    AST_STB_NO_ZERO: assert property (@(posedge clk) disable iff (rst)
        !strobe_o[0]); // R3

endmodule

// File: rtl/io_decoder.sv
module io_decoder
    import io_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cpu_state,
    input  logic [N_W-1:0]    n_field,
    input  logic              tpa,
    input  logic              tpb,
    input  logic              mod_en,
    output logic [SYNC_N-1:0] io_sync,
    output logic [STB_N-1:0]  io_strobe,
    output logic              io_dir
);

    io_cmd_t          cmd;
    logic             wr_act;
    logic [IDX_W-1:0] idx;

    io_cmd_decode i_dec (
        .state_i (cpu_state),
        .n_i     (n_field),
        .en_i    (mod_en),
        .cmd_o   (cmd)
    );

    io_sync_frame i_frame (
        .clk      (clk),
        .rst      (rst),
        .tpa_i    (tpa),
        .cmd_i    (cmd),
        .sync_o   (io_sync),
        .rd_o     (io_dir),
        .wr_act_o (wr_act),
        .idx_o    (idx)
    );

    io_strobe_gen i_stb (
        .clk      (clk),
        .rst      (rst),
        .tpb_i    (tpb),
        .wr_act_i (wr_act),
        .idx_i    (idx),
        .strobe_o (io_strobe)
    );

    AST_CLEAR_QUIET: assert property (@(posedge clk)
        rst |=> (io_sync == '0) && (io_strobe == '0) && !io_dir); // R8
    AST_STB_HAS_SYNC: assert property (@(posedge clk) disable iff (rst)
        (|io_strobe) |-> (|io_sync[STB_N-1:0])); // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tpa && !mod_en) |=> (io_sync == '0) && !io_dir); // R7

endmodule

// File: tb/test_io_decoder.sv
module test_io_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cpu_state = 2'b00;
    logic [3:0]  n_field = 4'h0;
    logic        tpa = 1'b0;
    logic        tpb = 1'b0;
    logic        mod_en = 1'b0;
    logic [15:0] io_sync;
    logic [7:0]  io_strobe;
    logic        io_dir;

    always #2 clk = ~clk;  // 250 MHz

    io_decoder i_io_decoder (
        .clk       (clk),
        .rst       (rst),
        .cpu_state (cpu_state),
        .n_field   (n_field),
        .tpa       (tpa),
        .tpb       (tpb),
        .mod_en    (mod_en),
        .io_sync   (io_sync),
        .io_strobe (io_strobe),
        .io_dir    (io_dir)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [24:0] exp_q[$];
    int          tag_q[$];

    logic [15:0] m_sync = '0;
    logic [7:0]  m_stb  = '0;
    logic        m_rd   = 1'b0;
    logic        m_wr   = 1'b0;
    logic [3:0]  m_sel  = '0;

    task automatic clk_step(input logic a, input logic b, input logic [1:0] s,
                            input logic [3:0] nn, input logic e, input logic r,
                            input int tag);
        logic       old_wr;
        logic [2:0] old_idx;
        logic       valid;
        tpa = a; tpb = b; cpu_state = s; n_field = nn; mod_en = e; rst = r;
        old_wr  = m_wr;
        old_idx = m_sel[2:0];
        if (r) begin
            m_sync = '0; m_stb = '0; m_rd = 0; m_wr = 0; m_sel = '0;
        end else begin
            if (a) begin
                valid  = e && (s == 2'b01) && (nn[2:0] != 3'd0);
                m_sync = valid ? (16'h1 << nn) : 16'h0;
                m_rd   = valid && nn[3];
                m_wr   = valid && !nn[3];
                m_sel  = nn;
            end
            m_stb = (b && old_wr) ? (8'h1 << old_idx) : 8'h0;
        end
        exp_q.push_back({m_sync, m_stb, m_rd});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic mcycle(input logic [1:0] s, input logic [3:0] nn, input logic e,
                          input int tag);
        clk_step(1, 0, s, nn, e, 0, tag);
        clk_step(0, 0, s, nn, e, 0, tag);
        clk_step(0, 0, s, nn, e, 0, tag);
        clk_step(0, 1, s, nn, e, 0, tag);
        clk_step(0, 0, s, nn, e, 0, tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [24:0] ex;
                int          tg;
                ex = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if ({io_sync, io_strobe, io_dir} !== ex) begin
                    errors++;
                    $display("FAIL R%0d: sync=%h strobe=%h dir=%b expected sync=%h strobe=%h dir=%b",
                             tg, io_sync, io_strobe, io_dir, ex[24:9], ex[8:1], ex[0]);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R8: reset state
        repeat (3) clk_step(0, 0, 2'b01, 4'h3, 1, 1, 8);
        // R2 R4 R5: write N=3
        mcycle(2'b01, 4'h3, 1, 5);
        // R4 R6: read N=B
        mcycle(2'b01, 4'hB, 1, 6);
        // R3: N=0 and N=8 silent
        mcycle(2'b01, 4'h0, 1, 3);
        mcycle(2'b01, 4'h8, 1, 3);
        // R1: non-execute states ignored
        mcycle(2'b00, 4'h5, 1, 1);
        mcycle(2'b10, 4'h2, 1, 1);
        mcycle(2'b11, 4'hC, 1, 1);
        // R7: module disabled
        mcycle(2'b01, 4'h6, 1, 7);
        mcycle(2'b01, 4'h6, 0, 7);
        // R9: non-I/O cycle after an I/O cycle clears outputs
        mcycle(2'b01, 4'hF, 1, 9);
        mcycle(2'b00, 4'h0, 1, 9);
        // R2: every N value in turn
        for (int k = 0; k < 16; k++) begin
            mcycle(2'b01, 4'(k), 1, 2);
        end
        // R8: clear in the middle of a write cycle
        clk_step(1, 0, 2'b01, 4'h7, 1, 0, 8);
        clk_step(0, 0, 2'b01, 4'h7, 1, 1, 8);
        clk_step(0, 1, 2'b01, 4'h7, 1, 0, 8);
        clk_step(0, 0, 2'b01, 4'h7, 1, 0, 8);
        // back-to-back writes with different devices, R5
        mcycle(2'b01, 4'h1, 1, 5);
        mcycle(2'b01, 4'h7, 1, 5);
        clk_step(0, 0, 2'b00, 4'h0, 1, 0, 5);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule